// File: doc/BRIEF.md
# Range to Prefix Expander

This unit turns an inclusive integer interval `[lo, hi]` on a `W`-bit field into the smallest set of maximal prefixes whose union is exactly that interval. Ternary match tables can hold prefixes but not arbitrary intervals, so a port-number interval has to be split before it is written into such a table. A caller offers `lo` and `hi` on a start handshake. The unit then streams the prefixes one per cycle on a valid/ready output. Each prefix comes out as a left-aligned value, a length, and the matching mask, and the final prefix carries a last flag.

The split is greedy. Starting from the current low bound, the unit takes the largest power-of-two block that is aligned at that bound and does not extend past `hi`. It emits that block and advances the bound past it, then repeats. The prefixes therefore come out in ascending order of their start value. A one-cycle `done` pulse ends each request. An empty interval (`lo > hi`) produces no prefixes, and its `done` pulse is accompanied by `err`.

Top module: `rpx_expander`

## Requirements
- R1: After reset `out_valid` and `done` are low and `start_ready` is high.
- R2: The emitted prefixes cover every integer in `[lo, hi]` exactly once and no integer outside it.
- R3: Every emitted prefix is maximal: the prefix one bit shorter that contains it is not wholly inside `[lo, hi]`.
- R4: Prefixes come out in strictly ascending order of start value. Each one is the largest aligned power-of-two block that starts at the current low bound and ends at or below `hi`.
- R5: `out_len` lies in 0..W. `out_mask` has ones in exactly its top `out_len` bits. `out_value` has zeros in every bit where the mask is zero.
- R6: A single interval never yields more than 2W-2 prefixes (W ≥ 2). For W=4, `[1,14]` yields six prefixes: 0001, 001, 01, 10, 110 and 1110.
- R7: The full interval `[0, 2^W-1]` yields a single prefix of length 0. An interval with `lo = hi` yields a single prefix of length W.
- R8: When `lo > hi`, no prefix is emitted. `done` and `err` are both high in the cycle after the request is taken.
- R9: `out_last` is high only on the final prefix. `done` pulses for one cycle, in the cycle after the final prefix is taken, with `err` low.
- R10: `start_ready` is low from the cycle after a request is taken through the `done` cycle. A `start_valid` raised during that time changes nothing.
- R11: While `out_valid` is high and `out_ready` is low, value, length, mask and last hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | A new interval is offered |
| start_ready | output | 1 | Unit is idle and will take the interval |
| start_lo | input | W | Lower bound, inclusive |
| start_hi | input | W | Upper bound, inclusive |
| out_valid | output | 1 | A prefix is presented |
| out_ready | input | 1 | Consumer takes the prefix |
| out_value | output | W | Prefix bits, left-aligned |
| out_mask | output | W | Ones in the top `out_len` bits |
| out_len | output | $clog2(W+1) | Prefix length, 0..W |
| out_last | output | 1 | Final prefix of this interval |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Request was empty (`lo > hi`), valid with `done` |

## Verification
The bench builds the unit with W=4. With that width every one of the 256 `(lo, hi)` pairs, empty ones included, can be run exhaustively. Both bound cases are reached: the six-prefix worst case `[1,14]` and the zero-length full span. The width also allows every prefix to be checked against a brute-force coverage map of all sixteen field values. The exhaustive sweep runs with random output back-pressure and with `start_valid` raised while the unit is busy.

// File: rtl/rpx_pkg.sv
package rpx_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_EMIT = 2'd1,
        PH_DONE = 2'd2
    } phase_t;

    // bits needed to hold a prefix length 0..w
    function automatic int len_bits(input int w);
        return $clog2(w + 1);
    endfunction

endpackage

// File: rtl/rpx_blocksel.sv
// Chooses the largest aligned power-of-two block starting at cur that
// stays at or below hi; reports its log2 size, the next bound and whether
// this block reaches hi.
module rpx_blocksel #(
    parameter int W  = 16,
    parameter int LW = 5
) (
    input  logic [W-1:0]  cur,
    input  logic [W-1:0]  hi,
    output logic [LW-1:0] size_log,
    output logic [W-1:0]  next_cur,
    output logic          is_last
);
    localparam int EW = W + 1;

    logic [EW-1:0] ext_cur;
    logic [EW-1:0] ext_hi;
    logic [EW-1:0] span;
    logic [EW-1:0] sel_span;
    logic [EW-1:0] blk_end;

    assign ext_cur = EW'(cur);
    assign ext_hi  = EW'(hi);

    always_comb begin
        size_log = '0;
        span     = '0;
        for (int k = 0; k <= W; k++) begin
            span = EW'(1) << k;
            if (((ext_cur & (span - EW'(1))) == '0) &&
                ((ext_cur + span - EW'(1)) <= ext_hi)) begin
                size_log = LW'(k);
            end
        end
    end

    assign sel_span = EW'(1) << size_log;
    assign blk_end  = ext_cur + sel_span - EW'(1);
    assign is_last  = (blk_end == ext_hi);
    assign next_cur = W'(blk_end + EW'(1));

endmodule

// File: rtl/rpx_fmt.sv
// Turns an aligned base and block size into the prefix triple.
module rpx_fmt #(
    parameter int W  = 16,
    parameter int LW = 5
) (
    input  logic [W-1:0]  base,
    input  logic [LW-1:0] size_log,
    output logic [W-1:0]  value,
    output logic [W-1:0]  mask,
    output logic [LW-1:0] len
);
    logic [W-1:0] low_ones;

    assign low_ones = W'((W + 1)'(1) << size_log) - W'(1);
    assign mask     = ~low_ones;
    assign value    = base;
    assign len      = LW'(W) - size_log;

endmodule

// File: rtl/rpx_expander.sv
module rpx_expander
    import rpx_pkg::*;
#(
    parameter int W = 16,
    localparam int LW = len_bits(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_valid,
    output logic          start_ready,
    input  logic [W-1:0]  start_lo,
    input  logic [W-1:0]  start_hi,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [W-1:0]  out_value,
    output logic [W-1:0]  out_mask,
    output logic [LW-1:0] out_len,
    output logic          out_last,
    output logic          done,
    output logic          err
);
    phase_t        phase;
    logic [W-1:0]  cur_q;
    logic [W-1:0]  hi_q;
    logic          err_q;

    logic [LW-1:0] blk_log;
    logic [W-1:0]  blk_next;
    logic          blk_last;

    rpx_blocksel #(.W(W), .LW(LW)) u_sel (
        .cur      (cur_q),
        .hi       (hi_q),
        .size_log (blk_log),
        .next_cur (blk_next),
        .is_last  (blk_last)
    );

    rpx_fmt #(.W(W), .LW(LW)) u_fmt (
        .base     (cur_q),
        .size_log (blk_log),
        .value    (out_value),
        .mask     (out_mask),
        .len      (out_len)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cur_q <= '0;
            hi_q  <= '0;
            err_q <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start_valid) begin
                        cur_q <= start_lo;
                        hi_q  <= start_hi;
                        err_q <= (start_lo > start_hi);
                        phase <= (start_lo > start_hi) ? PH_DONE : PH_EMIT;
                    end
                end
                PH_EMIT: begin
                    if (out_ready) begin
                        if (blk_last) phase <= PH_DONE;
                        else          cur_q <= blk_next;
                    end
                end
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign start_ready = (phase == PH_IDLE);
    assign out_valid   = (phase == PH_EMIT);
    assign out_last    = out_valid & blk_last;
    assign done        = (phase == PH_DONE);
    assign err         = done & err_q;

endmodule

// File: rtl/rpx_expander_chk.sv
module rpx_expander_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         start_valid,
    input logic         start_ready,
    input logic [W-1:0] start_lo,
    input logic [W-1:0] start_hi,
    input logic         out_valid,
    input logic         out_ready,
    input logic [W-1:0] out_value,
    input logic [W-1:0] out_mask,
    input logic         out_last,
    input logic         done,
    input logic         err
);
    // R5
    value_in_mask_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_value & ~out_mask) == '0));

    // R11
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_value) && $stable(out_mask) && $stable(out_last)));

    // R4
    ascending_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_last) |=> (out_valid && (out_value > $past(out_value))));

    // R9
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(out_valid && out_ready && out_last) ||
                  $past(start_valid && start_ready && (start_lo > start_hi))));

    // R8
    err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R10
    idle_xor_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !(start_ready && (out_valid || done)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

bind rpx_expander rpx_expander_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_valid (start_valid),
    .start_ready (start_ready),
    .start_lo    (start_lo),
    .start_hi    (start_hi),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_value   (out_value),
    .out_mask    (out_mask),
    .out_last    (out_last),
    .done        (done),
    .err         (err)
);

// File: tb/test_rpx_expander.sv
module test_rpx_expander;
    localparam int W  = 4;
    localparam int LW = $clog2(W + 1);
    localparam int SPAN = 1 << W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_valid = 1'b0;
    logic          start_ready;
    logic [W-1:0]  start_lo = '0;
    logic [W-1:0]  start_hi = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [W-1:0]  out_value;
    logic [W-1:0]  out_mask;
    logic [LW-1:0] out_len;
    logic          out_last;
    logic          done;
    logic          err;

    int checks = 0;
    int errors = 0;
    int got_v[$];
    int got_l[$];

    rpx_expander #(.W(W)) i_rpx_expander (
        .clk(clk), .rst(rst),
        .start_valid(start_valid), .start_ready(start_ready),
        .start_lo(start_lo), .start_hi(start_hi),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_value(out_value), .out_mask(out_mask), .out_len(out_len),
        .out_last(out_last), .done(done), .err(err)
    );

    always #2.5ns clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // greedy reference written with plain integers
    task automatic model(input int lo, input int hi, ref int ev[$], ref int el[$]);
        int x;
        int k;
        ev.delete();
        el.delete();
        x = lo;
        while (x <= hi) begin
            k = W;
            while (k > 0 && (((x % (1 << k)) != 0) || (x + (1 << k) - 1 > hi))) k--;
            ev.push_back(x);
            el.push_back(W - k);
            x += (1 << k);
        end
    endtask

    function automatic int mask_of(input int len);
        return ((SPAN - 1) << (W - len)) & (SPAN - 1);
    endfunction

    task automatic run_range(input int lo, input int hi, input bit stall, input bit poke);
        int ev[$];
        int el[$];
        int n;
        bit fin;
        model(lo, hi, ev, el);
        got_v.delete();
        got_l.delete();
        @(negedge clk);
        chk(start_ready == 1'b1, "R10 idle before start", int'(start_ready), 1);
        start_valid = 1'b1;
        start_lo = W'(lo);
        start_hi = W'(hi);
        @(negedge clk);
        start_valid = poke;
        start_lo = ~start_lo;
        start_hi = ~start_hi;
        n = 0;
        fin = 1'b0;
        for (int guard = 0; guard < 64 && !fin; guard++) begin
            if (done) begin
                chk(n == ev.size(), "R2 prefix count", n, ev.size());
                chk(err == (lo > hi), "R8 err with done", int'(err), int'(lo > hi));
                chk(out_valid == 1'b0, "R9 no output at done", int'(out_valid), 0);
                start_valid = 1'b0;
                fin = 1'b1;
            end else begin
                chk(start_ready == 1'b0, "R10 busy", int'(start_ready), 0);
                if (n >= ev.size()) begin
                    chk(out_valid == 1'b0, "R8 no prefix", int'(out_valid), 0);
                end else begin
                    chk(out_valid == 1'b1, "R4 valid", int'(out_valid), 1);
                    chk(int'(out_value) == ev[n], "R4 value", int'(out_value), ev[n]);
                    chk(int'(out_len) == el[n], "R4 length", int'(out_len), el[n]);
                    chk(int'(out_mask) == mask_of(el[n]), "R5 mask", int'(out_mask), mask_of(el[n]));
                    chk(out_last == (n == ev.size() - 1), "R9 last", int'(out_last), int'(n == ev.size() - 1));
                end
                out_ready = stall ? 1'($urandom_range(0, 1)) : 1'b1;
                if (out_valid && out_ready) begin
                    got_v.push_back(int'(out_value));
                    got_l.push_back(int'(out_len));
                    n++;
                end
                @(negedge clk);
            end
        end
        if (!fin) chk(1'b0, "R9 done never seen", 0, 1);
        start_valid = 1'b0;
        out_ready = 1'b1;
    endtask

    // checks on the collected prefixes that need no model
    task automatic props(input int lo, input int hi);
        int cnt;
        int pm;
        int pv;
        for (int x = 0; x < SPAN; x++) begin
            cnt = 0;
            foreach (got_v[i]) if ((x & mask_of(got_l[i])) == got_v[i]) cnt++;
            chk(cnt == ((x >= lo && x <= hi) ? 1 : 0), "R2 coverage", cnt, (x >= lo && x <= hi) ? 1 : 0);
        end
        foreach (got_v[i]) begin
            if (got_l[i] > 0) begin
                pm = mask_of(got_l[i] - 1);
                pv = got_v[i] & pm;
                chk(!(pv >= lo && (pv | (~pm & (SPAN - 1))) <= hi), "R3 maximal", got_v[i], -1);
            end
            if (i > 0) chk(got_v[i] > got_v[i-1], "R4 ascending", got_v[i], got_v[i-1]);
        end
        chk(got_v.size() <= 2 * W - 2, "R6 bound", got_v.size(), 2 * W - 2);
    endtask

    task automatic check_list(input string req, input int ev[$], input int el[$]);
        chk(got_v.size() == ev.size(), req, got_v.size(), ev.size());
        foreach (ev[i]) begin
            if (i < got_v.size()) begin
                chk(got_v[i] == ev[i], req, got_v[i], ev[i]);
                chk(got_l[i] == el[i], req, got_l[i], el[i]);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(start_ready == 1'b1, "R1 start_ready", int'(start_ready), 1);

        // worked examples (R4, R6)
        run_range(3, 11, 1'b0, 1'b0);
        check_list("R4 [3,11]", '{3, 4, 8}, '{4, 2, 2});
        run_range(2, 7, 1'b0, 1'b0);
        check_list("R4 [2,7]", '{2, 4}, '{3, 2});
        run_range(4, 7, 1'b1, 1'b0);
        check_list("R4 [4,7]", '{4}, '{2});
        run_range(1, 14, 1'b1, 1'b0);
        check_list("R6 [1,14]", '{1, 2, 4, 8, 12, 14}, '{4, 3, 2, 2, 3, 4});
        // R7
        run_range(0, SPAN - 1, 1'b0, 1'b0);
        check_list("R7 full", '{0}, '{0});
        run_range(9, 9, 1'b0, 1'b0);
        check_list("R7 single", '{9}, '{W});
        // R8
        run_range(7, 3, 1'b0, 1'b1);
        chk(got_v.size() == 0, "R8 empty", got_v.size(), 0);

        // exhaustive sweep, stalls (R11) and busy pokes (R10)
        for (int lo = 0; lo < SPAN; lo++) begin
            for (int hi = 0; hi < SPAN; hi++) begin
                run_range(lo, hi, 1'b1, ((lo + hi) % 2) == 1);
                if (lo <= hi) props(lo, hi);
            end
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule